// File: doc/BRIEF.md
# Shared-Bus Multi-Cycle Processor Core

This block is a small processor core in which every data movement travels over one 9-bit bus. Eight general registers, an operand latch, a result latch and an instruction latch all read from that single bus. A multiplexer picks what drives it: one general register, the result latch, or the external data input. A sequencer captures a 9-bit instruction word from the data input when the start strobe is high. It then performs one bus transfer per clock and pulses a completion flag in the last step of the instruction.

Four operations are supported: register copy, load of an immediate value, addition and subtraction. Addition and subtraction take three steps after the fetch. The first operand goes into the operand latch, the sum or difference goes into the result latch, and the result is written back to the destination register. An immediate value is not part of the instruction word. It is presented on the data input in the cycle after the word is captured. The current bus value is brought out on a port so that a host can observe register contents.

Top module: `bus_proc`

## Requirements
- R1: While reset is high, and in the idle fetch step with the start strobe low, the completion flag stays at 0 and no instruction executes.
- R2: A word on the data input is captured as an instruction only at the clock edge where the sequencer is idle and the start strobe is 1. The strobe and the data input are ignored while an add or subtract is in progress.
- R3: Instruction bits [8:6] hold the opcode, [5:3] the destination register x and [2:0] the source register y. Opcode 000 (copy) finishes in the cycle after capture. In that cycle the flag is 1, the bus shows register y, and register x takes that value.
- R4: Opcode 001 (immediate) finishes in the cycle after capture. The data input of that cycle is on the bus and is written to register x, and bits [2:0] of the word have no effect.
- R5: Opcode 010 (add) raises the flag in the third cycle after capture and not before. In that cycle the bus shows (x + y) mod 512, which is written to register x.
- R6: Opcode 011 (subtract) follows the same timing as add. It writes (x - y) mod 512 to register x, and the bus shows that value in the final cycle.
- R7: Opcodes 100 to 111 change no register and raise the flag in the cycle after capture.
- R8: The flag is a single-cycle pulse. With the start strobe held at 1, a new word is captured in the cycle after the flag, so instructions run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Start strobe, sampled in the idle fetch step |
| din | input | 9 | Instruction word, or immediate value in the step after an immediate word |
| done | output | 1 | Completion pulse in the last step of an instruction |
| bus_view | output | 9 | Current value on the shared bus |

## Verification
The assertions assume that the sequencer only leaves the fetch step through a captured word. They also assume that the operand latch and the bus in the add/subtract combine step are the only inputs to the result latch, so the result they check is built from those values one cycle earlier. They assume nothing about when the strobe is raised. The stimulus changes the data input and the strobe only on falling edges, and it presents each immediate value in the cycle after its word. It also drives junk onto the data input, and keeps the strobe high, during arithmetic steps to show that both are ignored there.

// File: rtl/bus_proc_pkg.sv
package bus_proc_pkg;
  localparam int OPW = 3;

  typedef enum logic [1:0] {
    ST_FETCH = 2'd0,
    ST_S1    = 2'd1,
    ST_S2    = 2'd2,
    ST_S3    = 2'd3
  } step_t;

  typedef enum logic [OPW-1:0] {
    OP_MV  = 3'b000,
    OP_MVI = 3'b001,
    OP_ADD = 3'b010,
    OP_SUB = 3'b011
  } op_t;

  typedef enum logic [1:0] {
    SRC_DIN = 2'd0,
    SRC_REG = 2'd1,
    SRC_RES = 2'd2
  } src_t;
endpackage

// File: rtl/bus_proc_regfile.sv
module bus_proc_regfile #(
  parameter int W    = 9,
  parameter int NREG = 8
) (
  input  logic                    clk,
  input  logic [NREG-1:0]         we,
  input  logic [W-1:0]            d,
  output logic [NREG-1:0][W-1:0]  q
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (we[i]) q[i] <= d;
    end
  end
endmodule

// File: rtl/bus_proc_alu.sv
module bus_proc_alu #(
  parameter int W = 9
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] y
);
  always_comb begin
    if (sub) y = a - b;
    else     y = a + b;
  end
endmodule

// File: rtl/bus_proc_ctrl.sv
module bus_proc_ctrl
  import bus_proc_pkg::*;
#(
  parameter int NREG = 8,
  localparam int IW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [OPW-1:0]  op_bits,
  input  logic [IW-1:0]   fx,
  input  logic [IW-1:0]   fy,
  output step_t           step,
  output logic            ir_we,
  output logic            a_we,
  output logic            g_we,
  output logic [NREG-1:0] reg_we,
  output src_t            src,
  output logic [IW-1:0]   rsel,
  output logic            sub,
  output logic            done
);
  step_t step_q, step_d;
  op_t   op;

  assign op   = op_t'(op_bits);
  assign step = step_q;

  always_ff @(posedge clk) begin
    if (rst) step_q <= ST_FETCH;
    else     step_q <= step_d;
  end

  always_comb begin
    step_d = step_q;
    ir_we  = 1'b0;
    a_we   = 1'b0;
    g_we   = 1'b0;
    reg_we = '0;
    src    = SRC_DIN;
    rsel   = fx;
    sub    = 1'b0;
    done   = 1'b0;
    case (step_q)
      ST_FETCH: begin
        if (run) begin
          ir_we  = 1'b1;
          step_d = ST_S1;
        end
      end
      ST_S1: begin
        case (op)
          OP_MV: begin
            src    = SRC_REG;
            rsel   = fy;
            reg_we = NREG'(1) << fx;
            done   = 1'b1;
            step_d = ST_FETCH;
          end
          OP_MVI: begin
            src    = SRC_DIN;
            reg_we = NREG'(1) << fx;
            done   = 1'b1;
            step_d = ST_FETCH;
          end
          OP_ADD, OP_SUB: begin
            src    = SRC_REG;
            rsel   = fx;
            a_we   = 1'b1;
            step_d = ST_S2;
          end
          default: begin
            done   = 1'b1;
            step_d = ST_FETCH;
          end
        endcase
      end
      ST_S2: begin
        src    = SRC_REG;
        rsel   = fy;
        g_we   = 1'b1;
        sub    = (op == OP_SUB);
        step_d = ST_S3;
      end
      ST_S3: begin
        src    = SRC_RES;
        reg_we = NREG'(1) << fx;
        done   = 1'b1;
        step_d = ST_FETCH;
      end
      default: step_d = ST_FETCH;
    endcase
  end
endmodule

// File: rtl/bus_proc.sv
module bus_proc
  import bus_proc_pkg::*;
#(
  parameter int W    = 9,
  parameter int NREG = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic [W-1:0] din,
  output logic         done,
  output logic [W-1:0] bus_view
);
  localparam int IW = $clog2(NREG);

  logic [W-1:0]           ir_q, a_q, g_q, alu_y, bus;
  logic [NREG-1:0][W-1:0] rf_q;
  logic [NREG-1:0]        reg_we;
  logic                   ir_we, a_we, g_we, sub;
  logic [IW-1:0]          rsel;
  src_t                   src;
  step_t                  step;
  logic [OPW-1:0]         op_bits;
  logic [IW-1:0]          fx, fy;

  assign op_bits = ir_q[W-1 -: OPW];
  assign fx      = ir_q[2*IW-1 -: IW];
  assign fy      = ir_q[IW-1:0];

  always_ff @(posedge clk) begin
    if (rst)        ir_q <= '0;
    else if (ir_we) ir_q <= din;
  end

  always_ff @(posedge clk) begin
    if (a_we) a_q <= bus;
    if (g_we) g_q <= alu_y;
  end

  always_comb begin
    case (src)
      SRC_REG: bus = rf_q[rsel];
      SRC_RES: bus = g_q;
      default: bus = din;
    endcase
  end

  assign bus_view = bus;

  bus_proc_ctrl #(.NREG(NREG)) i_ctrl (
    .clk(clk), .rst(rst), .run(run), .op_bits(op_bits), .fx(fx), .fy(fy),
    .step(step), .ir_we(ir_we), .a_we(a_we), .g_we(g_we), .reg_we(reg_we),
    .src(src), .rsel(rsel), .sub(sub), .done(done)
  );

  bus_proc_regfile #(.W(W), .NREG(NREG)) i_rf (
    .clk(clk), .we(reg_we), .d(bus), .q(rf_q)
  );

  bus_proc_alu #(.W(W)) i_alu (
    .a(a_q), .b(bus), .sub(sub), .y(alu_y)
  );
endmodule

// File: rtl/bus_proc_chk.sv
module bus_proc_chk
  import bus_proc_pkg::*;
#(
  parameter int W = 9
) (
  input logic           clk,
  input logic           rst,
  input logic           run,
  input logic [W-1:0]   din,
  input logic           done,
  input logic [W-1:0]   bus_view,
  input step_t          step,
  input logic [OPW-1:0] op_bits,
  input logic [W-1:0]   a_q,
  input logic [W-1:0]   g_q
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (step == ST_FETCH) |-> !done);

  p_fetch_start_r2: assert property (@(posedge clk) disable iff (rst)
    (step == ST_FETCH && run) |=> (step == ST_S1));

  p_fetch_wait_r2: assert property (@(posedge clk) disable iff (rst)
    (step == ST_FETCH && !run) |=> (step == ST_FETCH));

  p_copy_ends_r3: assert property (@(posedge clk) disable iff (rst)
    (step == ST_S1 && op_bits == 3'b000) |-> done);

  p_imm_bus_r4: assert property (@(posedge clk) disable iff (rst)
    (step == ST_S1 && op_bits == 3'b001) |-> (done && bus_view == din));

  p_arith_seq_r5: assert property (@(posedge clk) disable iff (rst)
    (step == ST_S1 && op_bits[2:1] == 2'b01) |=> (step == ST_S2 && !done));

  p_result_r6: assert property (@(posedge clk) disable iff (rst)
    (step == ST_S3) |-> (done && bus_view == g_q &&
      g_q == (($past(op_bits) == 3'b011) ? $past(a_q) - $past(bus_view)
                                         : $past(a_q) + $past(bus_view))));

  p_undef_ends_r7: assert property (@(posedge clk) disable iff (rst)
    (step == ST_S1 && op_bits[2]) |-> done);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

bind bus_proc bus_proc_chk #(.W(W)) i_chk (
  .clk(clk), .rst(rst), .run(run), .din(din), .done(done),
  .bus_view(bus_view), .step(step), .op_bits(op_bits),
  .a_q(a_q), .g_q(g_q)
);

// File: tb/test_bus_proc.sv
module test_bus_proc;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       run = 1'b0;
  logic [8:0] din = '0;
  logic       done;
  logic [8:0] bus_view;

  int n_checks = 0;
  int n_errors = 0;
  logic [8:0] mdl [8];

  always #(PERIOD/2) clk = ~clk;

  bus_proc i_bus_proc (
    .clk(clk), .rst(rst), .run(run), .din(din),
    .done(done), .bus_view(bus_view)
  );

  task automatic check(input string req, input string what,
                       input logic [8:0] act, input logic [8:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [8:0] word(input logic [2:0] op,
                                      input logic [2:0] x, input logic [2:0] y);
    return {op, x, y};
  endfunction

  // Copy: also used to read a register through the bus (R3).
  task automatic t_mv(input logic [2:0] x, input logic [2:0] y);
    @(negedge clk); run = 1'b1; din = word(3'b000, x, y);
    @(negedge clk); run = 1'b0; din = 9'h0AA; #1;
    check("R3", "copy done", {8'd0, done}, 9'd1);
    check("R3", "copy bus", bus_view, mdl[y]);
    mdl[x] = mdl[y];
  endtask

  task automatic t_mvi(input logic [2:0] x, input logic [2:0] yj,
                       input logic [8:0] imm);
    @(negedge clk); run = 1'b1; din = word(3'b001, x, yj);
    @(negedge clk); run = 1'b0; din = imm; #1;
    check("R4", "imm done", {8'd0, done}, 9'd1);
    check("R4", "imm bus", bus_view, imm);
    mdl[x] = imm;
  endtask

  task automatic t_arith(input logic is_sub, input logic [2:0] x,
                         input logic [2:0] y, input logic hold_run);
    logic [8:0] exp;
    string req;
    req = is_sub ? "R6" : "R5";
    exp = is_sub ? mdl[x] - mdl[y] : mdl[x] + mdl[y];
    @(negedge clk); run = 1'b1; din = word(is_sub ? 3'b011 : 3'b010, x, y);
    @(negedge clk); run = hold_run; din = 9'h1F7; #1;
    check(req, "step1 done", {8'd0, done}, 9'd0);
    @(negedge clk); din = word(3'b001, 3'd0, 3'd0); #1;
    check(req, "step2 done", {8'd0, done}, 9'd0);
    @(negedge clk); run = 1'b0; #1;
    check(req, "step3 done", {8'd0, done}, 9'd1);
    check(req, "result bus", bus_view, exp);
    mdl[x] = exp;
  endtask

  task automatic t_reset;
    rst = 1'b1; run = 1'b0;
    repeat (3) @(negedge clk);
    #1 check("R1", "done in reset", {8'd0, done}, 9'd0);
    @(negedge clk); rst = 1'b0; din = word(3'b001, 3'd1, 3'd0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1;
      check("R1", "idle done", {8'd0, done}, 9'd0);
    end
  endtask

  task automatic t_fill;
    for (int r = 0; r < 8; r++) t_mvi(3'(r), 3'(7 - r), 9'(r * 37 + 5));
    for (int r = 0; r < 8; r++) t_mv(3'(r), 3'(r));
  endtask

  task automatic t_imm_ignores_y;
    t_mvi(3'd2, 3'd5, 9'h155);
    t_mv(3'd2, 3'd2);
    t_mv(3'd5, 3'd5);   // R4: y field register untouched
  endtask

  task automatic t_math;
    t_mvi(3'd3, 3'd0, 9'h1F0);
    t_mvi(3'd4, 3'd0, 9'h020);
    t_arith(1'b0, 3'd3, 3'd4, 1'b0);   // R5 wraps to 0x010
    t_mv(3'd3, 3'd3);
    t_arith(1'b1, 3'd4, 3'd3, 1'b0);   // R6 0x020-0x010
    t_mvi(3'd6, 3'd0, 9'h005);
    t_mvi(3'd7, 3'd0, 9'h009);
    t_arith(1'b1, 3'd6, 3'd7, 1'b0);   // R6 borrow wraps
    t_mv(3'd6, 3'd6);
    t_arith(1'b0, 3'd1, 3'd1, 1'b1);   // R5 doubling, R2 strobe held
    t_mv(3'd1, 3'd1);
    t_mv(3'd0, 3'd0);                  // R2 junk word not executed
  endtask

  task automatic t_undef;
    for (int op = 4; op < 8; op++) begin
      @(negedge clk); run = 1'b1; din = word(3'(op), 3'd2, 3'd3);
      @(negedge clk); run = 1'b0; #1;
      check("R7", "undef done", {8'd0, done}, 9'd1);
    end
    for (int r = 0; r < 8; r++) t_mv(3'(r), 3'(r));  // R7 nothing changed
  endtask

  task automatic t_back_to_back;
    @(negedge clk); run = 1'b1; din = word(3'b001, 3'd5, 3'd0);
    @(negedge clk); din = 9'h0C3; #1;
    check("R8", "first done", {8'd0, done}, 9'd1);
    mdl[5] = 9'h0C3;
    @(negedge clk); din = word(3'b000, 3'd0, 3'd5); #1;
    check("R8", "pulse width", {8'd0, done}, 9'd0);
    @(negedge clk); run = 1'b0; #1;
    check("R8", "second done", {8'd0, done}, 9'd1);
    check("R8", "second bus", bus_view, 9'h0C3);
    mdl[0] = 9'h0C3;
    @(negedge clk); #1;
    check("R8", "after second", {8'd0, done}, 9'd0);
    t_mv(3'd0, 3'd0);
  endtask

  initial begin
    #(PERIOD * 100000);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    t_reset();
    t_fill();
    t_imm_ignores_y();
    t_math();
    t_undef();
    t_back_to_back();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule